// File: doc/BRIEF.md
# Display-List Coprocessor with Beam-Position Wait

This block walks a list of two-word commands held in chip memory and carries them out in step with the video beam. It reads one word each time the DMA arbiter grants it a slot, and it reports through `slot_used_o` whether it took that slot. There are three commands. A register-write command places a 16-bit value on a 9-bit register address. A wait command parks the engine until the beam reaches a masked position, and it can also hold until the blitter is idle. A skip command evaluates the same condition and, when it holds, cancels the next command if that command is a register write.

Software points the engine at a list with `start_addr_i` and a `restart_i` pulse. Writes to the lowest register addresses are refused: the engine halts instead of writing. A control input relaxes this guard for the second band of addresses. Memory reads are synchronous: the word addressed in a used slot is presented on `mem_data_i` during the following cycle. Grant strobes must be separated by at least one idle cycle.

Top module: `dlist_engine`

## Requirements
- R1: Each command is two 16-bit words read from consecutive word addresses. The fetch pointer steps by one on every used slot and wraps modulo 2^AW.
- R2: A command whose first word has bit 0 clear is a register write. Its address is first-word bits 8..1 with bit 0 forced to 0, and its data is the whole second word. `reg_we_o` pulses for one cycle, two cycles after the slot that fetched the second word.
- R3: For wait and skip, the mask is bit 15 set, bits 14..1 copied from the second word, and bit 0 clear. The beam part of the condition holds when (beam AND mask) is greater than or equal to (first word AND mask), compared unsigned.
- R4: Blitter busy is bit 14 of `blit_stat_i`. When bit 15 of the second word is clear, the condition also requires that bit to be 0. When bit 15 is set, the blitter is ignored.
- R5: First-word bit 0 set with second-word bit 0 clear is a wait. While waiting, the engine uses no slots. It tests the condition on each grant strobe, and after a passing test it fetches on the next strobe.
- R6: First-word bit 0 set with second-word bit 0 set is a skip. It latches its condition as a flag. The flag is cleared when the next command's second word is read, and it cancels that command only if that command is a register write. A following wait or skip runs normally.
- R7: A register write to an address below 0x010, or below 0x020 while `danger_en_i` is 0, performs no write and halts the engine. A write cancelled by a skip is not checked.
- R8: After reset the engine is halted. A halted engine uses no slots and issues no writes until restarted.
- R9: `restart_i` loads the pointer from `start_addr_i`, clears the skip flag and starts fetching on the next grant strobe. It takes priority over a strobe in the same cycle.
- R10: `slot_used_o` is high exactly on grant strobes where a word is fetched. At those strobes `mem_addr_o` holds the word address being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | DMA slot grant strobe |
| beam_i | input | 16 | Beam position: vertical in 15..8, horizontal in 7..1 |
| blit_stat_i | input | 16 | Blitter status, bit 14 = busy |
| start_addr_i | input | AW | List start word address |
| restart_i | input | 1 | Load pointer and start fetching |
| danger_en_i | input | 1 | Permit writes to addresses 0x010..0x01E |
| mem_addr_o | output | AW | Word address for the memory read |
| mem_data_i | input | 16 | Read data, valid the cycle after a used slot |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 9 | Register write address |
| reg_data_o | output | 16 | Register write data |
| slot_used_o | output | 1 | Slot taken for a fetch (memory read enable) |

## Verification
A skip's flag is consumed during the same decode in which the following register write runs its address guard, so two functions meet in one cycle. The bench provokes this by placing a true skip directly before a write to a forbidden address. It judges the result by the absence of a halt: the next legal write must still appear, and it must not appear when the skip is false. Constrained-random lists mix all three commands, skips with random masks and random blitter states. They run against a command-level model that predicts the exact sequence of writes and whether the list ends halted or parked.

// File: rtl/dle_pkg.sv
package dle_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned RADDR_W = 9;

  typedef enum logic [1:0] {
    ST_HALT    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_FETCH_A = 2'd2,
    ST_FETCH_B = 2'd3
  } dle_state_e;
endpackage

// File: rtl/dle_cond.sv
module dle_cond
  import dle_pkg::*;
(
  input  logic [WORD_W-1:0] beam_i,
  input  logic [WORD_W-1:0] blit_stat_i,
  input  logic [WORD_W-1:0] cmd_a_i,
  input  logic [WORD_W-1:0] cmd_b_i,
  output logic              pass_o
);
  localparam int unsigned BUSY_BIT = 14;
  localparam int unsigned IGN_BIT  = WORD_W - 1;

  logic [WORD_W-1:0] mask;
  logic              raster_ok;
  logic              blit_ok;
  logic              unused_stat;

  always_comb begin
    mask      = {1'b1, cmd_b_i[WORD_W-2:1], 1'b0};
    raster_ok = (beam_i & mask) >= (cmd_a_i & mask);
    blit_ok   = !blit_stat_i[BUSY_BIT] || cmd_b_i[IGN_BIT];
    pass_o    = raster_ok && blit_ok;
  end

  assign unused_stat = ^{blit_stat_i[WORD_W-1], blit_stat_i[BUSY_BIT-1:0]};
endmodule

// File: rtl/dle_ptr.sv
module dle_ptr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load_i || step_i;
    ptr_d  = load_i ? load_val_i : AW'(ptr_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (ptr_o == AW'($past(ptr_o) + 1'b1))); // R1
endmodule

// File: rtl/dle_guard.sv
module dle_guard
  import dle_pkg::*;
(
  input  logic [WORD_W-1:0]  cmd_a_i,
  input  logic               danger_en_i,
  output logic [RADDR_W-1:0] addr_o,
  output logic               fault_o
);
  localparam logic [RADDR_W-1:0] HARD_LIMIT = RADDR_W'(9'h010);
  localparam logic [RADDR_W-1:0] SOFT_LIMIT = RADDR_W'(9'h020);

  logic unused_bits;

  always_comb begin
    addr_o  = {cmd_a_i[RADDR_W-1:1], 1'b0};
    fault_o = (addr_o < HARD_LIMIT) || ((addr_o < SOFT_LIMIT) && !danger_en_i);
  end

  assign unused_bits = ^{cmd_a_i[WORD_W-1:RADDR_W], cmd_a_i[0]};
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
  import dle_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_i,
  input  logic [WORD_W-1:0]  beam_i,
  input  logic [WORD_W-1:0]  blit_stat_i,
  input  logic [AW-1:0]      start_addr_i,
  input  logic               restart_i,
  input  logic               danger_en_i,
  output logic [AW-1:0]      mem_addr_o,
  input  logic [WORD_W-1:0]  mem_data_i,
  output logic               reg_we_o,
  output logic [RADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0]  reg_data_o,
  output logic               slot_used_o
);
  dle_state_e         state_q, state_d;
  logic [WORD_W-1:0]  w1_q, w1_d;
  logic [WORD_W-1:0]  w2_q, w2_d;
  logic               skip_q, skip_d;
  logic               rsp_a_q, rsp_a_d;
  logic               rsp_b_q, rsp_b_d;
  logic               we_q, we_d;
  logic [RADDR_W-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0]  wdata_q, wdata_d;

  logic [WORD_W-1:0]  cond_b;
  logic               cond_pass;
  logic [RADDR_W-1:0] guard_addr;
  logic               guard_fault;
  logic               take_slot;

  // slot acceptance: only while fetching and no second-word response is outstanding
  always_comb begin
    take_slot = slot_i && !restart_i &&
                ((state_q == ST_FETCH_A) || ((state_q == ST_FETCH_B) && !rsp_b_q));
    cond_b    = (state_q == ST_HOLD) ? w2_q : mem_data_i;
  end

  dle_ptr #(.AW(AW)) ptr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (restart_i),
    .load_val_i (start_addr_i),
    .step_i     (take_slot),
    .ptr_o      (mem_addr_o)
  );

  dle_cond cond_i (
    .beam_i      (beam_i),
    .blit_stat_i (blit_stat_i),
    .cmd_a_i     (w1_q),
    .cmd_b_i     (cond_b),
    .pass_o      (cond_pass)
  );

  dle_guard guard_i (
    .cmd_a_i     (w1_q),
    .danger_en_i (danger_en_i),
    .addr_o      (guard_addr),
    .fault_o     (guard_fault)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    w1_d    = w1_q;
    w2_d    = w2_q;
    skip_d  = skip_q;
    rsp_a_d = 1'b0;
    rsp_b_d = 1'b0;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;

    if (restart_i) begin
      state_d = ST_FETCH_A;
      skip_d  = 1'b0;
    end else begin
      if (rsp_a_q) begin
        w1_d = mem_data_i;
      end
      unique case (state_q)
        ST_HALT: ;
        ST_HOLD: begin
          if (slot_i && cond_pass) begin
            state_d = ST_FETCH_A;
          end
        end
        ST_FETCH_A: begin
          if (take_slot) begin
            state_d = ST_FETCH_B;
            rsp_a_d = 1'b1;
          end
        end
        ST_FETCH_B: begin
          if (rsp_b_q) begin
            w2_d   = mem_data_i;
            skip_d = 1'b0;
            if (!w1_q[0]) begin
              if (!skip_q && guard_fault) begin
                state_d = ST_HALT;
              end else begin
                state_d = ST_FETCH_A;
                if (!skip_q) begin
                  we_d    = 1'b1;
                  waddr_d = guard_addr;
                  wdata_d = mem_data_i;
                end
              end
            end else if (!mem_data_i[0]) begin
              state_d = ST_HOLD;
            end else begin
              skip_d  = cond_pass;
              state_d = ST_FETCH_A;
            end
          end else if (take_slot) begin
            rsp_b_d = 1'b1;
          end
        end
        default: state_d = ST_HALT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HALT;
      w1_q    <= '0;
      w2_q    <= '0;
      skip_q  <= 1'b0;
      rsp_a_q <= 1'b0;
      rsp_b_q <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      w1_q    <= w1_d;
      w2_q    <= w2_d;
      skip_q  <= skip_d;
      rsp_a_q <= rsp_a_d;
      rsp_b_q <= rsp_b_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign slot_used_o = take_slot;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = waddr_q;
  assign reg_data_o  = wdata_q;

  AST_WE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_addr_o[0] == 1'b0)); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o); // R2
  AST_WE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> ((reg_addr_o >= 9'h020) || ((reg_addr_o >= 9'h010) && $past(danger_en_i)))); // R7
  AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HOLD) && !restart_i && !(slot_i && cond_pass)) |=> (state_q == ST_HOLD)); // R5
  AST_HOLD_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !slot_used_o); // R5
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HALT) && !restart_i) |=> (state_q == ST_HALT)); // R8
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HALT) && ($past(state_q) == ST_HALT)) |-> (!reg_we_o && !slot_used_o)); // R8
endmodule

// File: tb/dlist_engine_tb_top.sv
`timescale 1ns/1ps
module dlist_engine_tb_top;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int LOGN  = 4096;

  logic          clk;
  logic          rst_n;
  logic          slot_i;
  logic [15:0]   beam_i;
  logic [15:0]   blit_stat_i;
  logic [AW-1:0] start_addr_i;
  logic          restart_i;
  logic          danger_en_i;
  logic [AW-1:0] mem_addr_o;
  logic [15:0]   mem_data_i;
  logic          reg_we_o;
  logic [8:0]    reg_addr_o;
  logic [15:0]   reg_data_o;
  logic          slot_used_o;

  logic [15:0] mem [DEPTH];
  logic        slot_run;
  int          n_chk;
  int          n_fail;

  logic [8:0]  got_a [LOGN];
  logic [15:0] got_d [LOGN];
  int          wr_total = 0;
  int          rd_total = 0;

  logic [8:0]  exp_a [64];
  logic [15:0] exp_d [64];
  int          exp_n;
  int          exp_end;

  dlist_engine #(.AW(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot_i),
    .beam_i       (beam_i),
    .blit_stat_i  (blit_stat_i),
    .start_addr_i (start_addr_i),
    .restart_i    (restart_i),
    .danger_en_i  (danger_en_i),
    .mem_addr_o   (mem_addr_o),
    .mem_data_i   (mem_data_i),
    .reg_we_o     (reg_we_o),
    .reg_addr_o   (reg_addr_o),
    .reg_data_o   (reg_data_o),
    .slot_used_o  (slot_used_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (slot_used_o) mem_data_i <= mem[mem_addr_o];
  end

  always @(negedge clk) begin
    if (reg_we_o) begin
      got_a[wr_total % LOGN] = reg_addr_o;
      got_d[wr_total % LOGN] = reg_data_o;
      wr_total = wr_total + 1;
    end
    if (slot_used_o) rd_total = rd_total + 1;
  end

  // grant strobes: one cycle high, one to three cycles low
  initial begin
    int gap;
    slot_i = 1'b0;
    gap = 0;
    forever begin
      @(negedge clk);
      if (gap == 0) begin
        slot_i = slot_run;
        gap = 1 + int'($urandom % 3);
      end else begin
        slot_i = 1'b0;
        gap = gap - 1;
      end
    end
  end

  function automatic logic cond_f(logic [15:0] a, logic [15:0] b, logic [15:0] beam, logic [15:0] st);
    logic [15:0] m;
    m = 16'h8000 | (b & 16'h7FFE);
    return ((beam & m) >= (a & m)) && (!st[14] || b[15]);
  endfunction

  function automatic logic bad_f(logic [15:0] a, logic dng);
    logic [8:0] ad;
    ad = {a[8:1], 1'b0};
    return (ad < 9'h010) || ((ad < 9'h020) && !dng);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put(input int at, input logic [15:0] a, input logic [15:0] b);
    mem[at % DEPTH]       = a;
    mem[(at + 1) % DEPTH] = b;
  endtask

  task automatic model_run(input int start, input logic [15:0] beam, input logic [15:0] st, input logic dng);
    int p;
    logic sk, use_sk;
    logic [15:0] a, b;
    p = start; sk = 1'b0; exp_n = 0; exp_end = 2;
    for (int k = 0; k < 64; k++) begin
      a = mem[p % DEPTH]; b = mem[(p + 1) % DEPTH]; p = (p + 2) % DEPTH;
      use_sk = sk; sk = 1'b0;
      if (!a[0]) begin
        if (!use_sk) begin
          if (bad_f(a, dng)) begin exp_end = 0; return; end
          exp_a[exp_n] = {a[8:1], 1'b0}; exp_d[exp_n] = b; exp_n = exp_n + 1;
        end
      end else if (!b[0]) begin
        if (!cond_f(a, b, beam, st)) begin exp_end = 1; return; end
      end else begin
        sk = cond_f(a, b, beam, st);
      end
    end
  endtask

  task automatic restart_at(input int at);
    @(negedge clk);
    start_addr_i = AW'(at);
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
  endtask

  task automatic compare_writes(input int base, input string req);
    check((wr_total - base) == exp_n, req, wr_total - base, exp_n);
    for (int i = 0; i < exp_n && i < (wr_total - base); i++) begin
      check((got_a[(base + i) % LOGN] == exp_a[i]) && (got_d[(base + i) % LOGN] == exp_d[i]), req,
            {got_a[(base + i) % LOGN], got_d[(base + i) % LOGN]}, {exp_a[i], exp_d[i]});
    end
  endtask

  task automatic quiet_check(input int cyc, input string req);
    int r0;
    r0 = rd_total;
    repeat (cyc) @(negedge clk);
    check(rd_total == r0, req, rd_total - r0, 0);
  endtask

  task automatic run_list(input int at, input logic [15:0] beam, input logic [15:0] st, input logic dng, input string req);
    int base;
    beam_i = beam; blit_stat_i = st; danger_en_i = dng;
    model_run(at, beam, st, dng);
    base = wr_total;
    restart_at(at);
    repeat (500) @(negedge clk);
    compare_writes(base, req);
    quiet_check(30, "R10 idle after list end");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, at, p, r;
    logic [15:0] a, b;
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; slot_run = 1'b0; restart_i = 1'b0; start_addr_i = '0;
    beam_i = '0; blit_stat_i = '0; danger_en_i = 1'b0; mem_data_i = '0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    slot_run = 1'b1;

    // R8: halted after reset, strobes ignored
    base = wr_total;
    quiet_check(40, "R8 reset halt no fetch");
    check(wr_total == base && reg_we_o == 1'b0, "R8 reset no write", wr_total - base, 0);

    // R1: wrap of the pointer across the top of memory
    put(DEPTH - 2, 16'h0040, 16'hAAAA);
    put(0, 16'h0042, 16'hBBBB);
    put(2, 16'h0000, 16'h0000);
    run_list(DEPTH - 2, 16'h0000, 16'h0000, 1'b0, "R1 wrap order");

    // R6 and R7: skip true cancels a write; skip false does not; wait after skip runs
    at = 16'h100;
    put(at,      16'h4001, 16'hFFFF);
    put(at + 2,  16'h0050, 16'h1111);
    put(at + 4,  16'h6001, 16'hFFFF);
    put(at + 6,  16'h0054, 16'h3333);
    put(at + 8,  16'h4001, 16'hFFFF);
    put(at + 10, 16'h0001, 16'h8000);
    put(at + 12, 16'h0052, 16'h2222);
    put(at + 14, 16'h0000, 16'h0000);
    put(at + 16, 16'h0000, 16'h0000);
    run_list(at, 16'h5000, 16'h0000, 1'b1, "R6 skip then wait");

    // R7: cancelled forbidden write is not checked; guard band depends on danger bit
    at = 16'h140;
    put(at,      16'h0001, 16'h8001);
    put(at + 2,  16'h0002, 16'h9999);
    put(at + 4,  16'h0060, 16'h4444);
    put(at + 6,  16'h001E, 16'h5555);
    put(at + 8,  16'h0062, 16'h6666);
    put(at + 10, 16'h000E, 16'h0000);
    run_list(at, 16'h0000, 16'h0000, 1'b0, "R7 guard danger off");
    run_list(at, 16'h0000, 16'h0000, 1'b1, "R7 guard danger on");
    check(exp_n == 3, "R7 model count", exp_n, 3);

    // R3 and R5: wait blocked below target, released at equality
    at = 16'h200;
    put(at,     16'h8041, 16'hFFFE);
    put(at + 2, 16'h0070, 16'h7777);
    put(at + 4, 16'h0000, 16'h0000);
    beam_i = 16'h3000; blit_stat_i = 16'h0000; danger_en_i = 1'b1;
    base = wr_total;
    restart_at(at);
    repeat (60) @(negedge clk);
    quiet_check(60, "R5 waiting uses no slot");
    check(wr_total == base, "R5 no write while waiting", wr_total - base, 0);
    beam_i = 16'h8040;
    repeat (40) @(negedge clk);
    check(wr_total == base + 1 && got_a[base % LOGN] == 9'h070 && got_d[base % LOGN] == 16'h7777,
          "R3 release at equal position", wr_total - base, 1);

    // R3: horizontal bits masked out let a lower horizontal beam pass
    at = 16'h220;
    put(at,     16'h40FF, 16'hFF00);
    put(at + 2, 16'h0072, 16'h1234);
    put(at + 4, 16'h0000, 16'h0000);
    run_list(at, 16'h4002, 16'h0000, 1'b1, "R3 masked compare");
    check(exp_n == 1, "R3 model count", exp_n, 1);

    // R4 and R9: blitter gate, then restart out of a parked wait
    at = 16'h240;
    put(at,     16'h0001, 16'h0000);
    put(at + 2, 16'h0074, 16'hCAFE);
    put(at + 4, 16'h0000, 16'h0000);
    beam_i = 16'hFFFE; blit_stat_i = 16'h4000;
    base = wr_total;
    restart_at(at);
    repeat (80) @(negedge clk);
    check(wr_total == base, "R4 busy blocks wait", wr_total - base, 0);
    blit_stat_i = 16'hBFFF;
    repeat (40) @(negedge clk);
    check(wr_total == base + 1 && got_d[base % LOGN] == 16'hCAFE, "R4 idle releases wait", wr_total - base, 1);
    put(at + 6, 16'h0001, 16'h0000);
    put(at + 8, 16'h0076, 16'hBEEF);
    blit_stat_i = 16'h4000;
    base = wr_total;
    restart_at(at + 6);
    repeat (60) @(negedge clk);
    check(wr_total == base, "R4 parked again", wr_total - base, 0);
    at = 16'h260;
    put(at,     16'h0001, 16'h8000);
    put(at + 2, 16'h0078, 16'hD00D);
    put(at + 4, 16'h0000, 16'h0000);
    restart_at(at);
    repeat (60) @(negedge clk);
    check(wr_total == base + 1 && got_a[base % LOGN] == 9'h078 && got_d[base % LOGN] == 16'hD00D,
          "R9 restart from wait and R4 ignore bit", wr_total - base, 1);

    // random lists
    for (int t = 0; t < 30; t++) begin
      at = int'($urandom % DEPTH);
      p = at;
      for (int k = 0; k < 18; k++) begin
        r = int'($urandom % 10);
        if (r < 5) begin
          a = 16'h0020 + 16'(2 * ($urandom % 240)); b = 16'($urandom);
        end else if (r == 5) begin
          a = 16'h0010 + 16'(2 * ($urandom % 8)); b = 16'($urandom);
        end else if (r < 8) begin
          a = 16'($urandom) | 16'h0001; b = 16'($urandom) | 16'h0001;
        end else if (r == 8) begin
          a = 16'h0001; b = 16'($urandom) & 16'hFFFE;
        end else begin
          a = 16'(2 * ($urandom % 8)); b = 16'($urandom);
        end
        put(p, a, b);
        p = p + 2;
      end
      put(p, 16'h0000, 16'h0000);
      put(p + 2, 16'h0004, 16'h0000);
      run_list(at, 16'($urandom), 16'($urandom), 1'($urandom), "R2 R6 random list");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule